// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block is the control unit of a low-speed vehicle bus transceiver. It watches a supply-good indication, the enable pin, the transmit-data pin and two already-filtered wake-up event pulses (one from the bus, one from a local wake switch). From these it sequences four operating modes: unpowered, pre-normal, normal and sleep. It drives the external regulator inhibit output, the transmit-path enable, the bus termination enable, a receive-pin override used as a wake-up interrupt, and a transmit-pin pull-down strength select that tells the host which source caused the wake-up.

Mode-change delays are counted in pulses of a timebase tick input, so the same logic serves any clock frequency. Entry into normal mode needs the enable pin held high for a parameterised number of ticks. Entry into sleep needs an enable falling edge taken while transmit data is high, then enable held low for a parameterised number of ticks. The current mode is exported as a 2-bit code so that the surrounding logic and the checks can observe it.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: While reset is asserted, and after reset until the first clock edge with supply_ok high, mode_o is 2'b00 (unpowered) and inh_on, tx_path_en, term_on, rxd_force_low and txd_strong_pd are all 0.
- R2: In unpowered mode, one clock edge with supply_ok high moves mode_o to 2'b01 (pre-normal) with inh_on=1, term_on=1, tx_path_en=0 and both wake flags (rxd_force_low, txd_strong_pd) at 0.
- R3: From any mode, a clock edge with supply_ok low moves mode_o to 2'b00 with every output at 0.
- R4: In pre-normal, normal mode (2'b10) is entered on the NORM_TICKS-th tick of an unbroken run of edges with en_pin high; a cycle with en_pin low restarts the count, and cycles with tick low do not advance it.
- R5: In normal mode inh_on, tx_path_en and term_on are 1 and rxd_force_low and txd_strong_pd are 0.
- R6: In normal mode, an edge where en_pin is 0 after being 1 on the previous edge while txd_pin is 1 arms a sleep request; sleep (2'b11) is entered on the SLEEP_TICKS-th tick after arming with en_pin still low; en_pin returning high before then cancels the request.
- R7: An enable falling edge taken while txd_pin is 0 arms nothing: the block stays in normal mode however long en_pin then stays low.
- R8: In sleep mode inh_on, tx_path_en, term_on, rxd_force_low and txd_strong_pd are all 0.
- R9: In sleep, a wake_local or wake_remote pulse moves the block to pre-normal on the next edge with inh_on=1, term_on=1 and rxd_force_low=1; txd_strong_pd is 1 for a local wake (also when both pulse together) and 0 for a remote-only wake.
- R10: In pre-normal, an edge with en_pin high clears rxd_force_low and txd_strong_pd on that edge, before normal mode is reached.
- R11: Wake pulses outside sleep mode change neither the mode nor the wake flags.
- R12: Sleep persists indefinitely without a wake pulse, whatever en_pin and txd_pin do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable for the mode delays |
| supply_ok | input | 1 | Supply above the undervoltage threshold |
| en_pin | input | 1 | Enable pin level (low when floating) |
| txd_pin | input | 1 | Transmit-data pin level |
| wake_remote | input | 1 | Filtered bus wake-up event pulse |
| wake_local | input | 1 | Filtered wake-switch event pulse |
| mode_o | output | 2 | Mode: 00 unpowered, 01 pre-normal, 10 normal, 11 sleep |
| inh_on | output | 1 | Regulator inhibit switch on |
| tx_path_en | output | 1 | Transmit and receive path enabled |
| term_on | output | 1 | Bus termination resistor enabled |
| rxd_force_low | output | 1 | Pull receive pin low as wake-up request |
| txd_strong_pd | output | 1 | Strong transmit-pin pull-down (local wake source) |

## Verification
The assertions watch on every cycle the rules that hold in one or two cycles: a lost supply forcing unpowered mode, sleep being reachable only from normal mode, enable high never leading directly into sleep, the wake flags existing only in pre-normal and being dropped by enable high, and the output combinations that each mode allows. The tick-counted delays, the cancel and restart of a pending mode change, the refusal of a falling edge taken while transmit data is low, the wake-source priority and the indefinite hold of sleep span many cycles and are shown only by the bench's directed scenarios, which count edges from each stimulus to the expected mode change.

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_PRE   = 2'b01,
        MODE_RUN   = 2'b10,
        MODE_SLEEP = 2'b11
    } mode_t;

    typedef struct packed {
        mode_t mode;
        logic  wake_flag;
        logic  src_local;
        logic  sleep_pend;
        logic  en_prev;
    } ctl_state_t;

endpackage

// File: rtl/xcvr_delay_timer.sv
module xcvr_delay_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = run && tick && (cnt_q == limit - CNT_W'(1));
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && tick) begin
            cnt_d = done ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/xcvr_mode_decode.sv
module xcvr_mode_decode
    import xcvr_mode_pkg::*;
(
    input  mode_t mode,
    input  logic  wake_flag,
    input  logic  src_local,
    output logic  inh_on,
    output logic  tx_path_en,
    output logic  term_on,
    output logic  rxd_force_low,
    output logic  txd_strong_pd
);

    logic awake;

    always_comb begin
        awake         = (mode == MODE_PRE) || (mode == MODE_RUN);
        inh_on        = awake;
        term_on       = awake;
        tx_path_en    = (mode == MODE_RUN);
        rxd_force_low = (mode == MODE_PRE) && wake_flag;
        txd_strong_pd = (mode == MODE_PRE) && wake_flag && src_local;
    end

endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
    import xcvr_mode_pkg::*;
#(
    parameter int NORM_TICKS  = 4,
    parameter int SLEEP_TICKS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       supply_ok,
    input  logic       en_pin,
    input  logic       txd_pin,
    input  logic       wake_remote,
    input  logic       wake_local,
    output logic [1:0] mode_o,
    output logic       inh_on,
    output logic       tx_path_en,
    output logic       term_on,
    output logic       rxd_force_low,
    output logic       txd_strong_pd
);

    localparam int MAX_TICKS = (NORM_TICKS > SLEEP_TICKS) ? NORM_TICKS : SLEEP_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] NORM_LIM  = CNT_W'(NORM_TICKS);
    localparam logic [CNT_W-1:0] SLEEP_LIM = CNT_W'(SLEEP_TICKS);

    ctl_state_t st_d, st_q;

    logic             t_clear, t_run, t_done;
    logic [CNT_W-1:0] t_limit;
    logic             en_fall;

    // delay timer control derived from the registered state
    always_comb begin
        t_clear = 1'b1;
        t_run   = 1'b0;
        t_limit = NORM_LIM;
        if (supply_ok) begin
            case (st_q.mode)
                MODE_PRE: begin
                    t_run   = en_pin;
                    t_clear = !en_pin;
                end
                MODE_RUN: begin
                    t_limit = SLEEP_LIM;
                    t_run   = st_q.sleep_pend && !en_pin;
                    t_clear = !t_run;
                end
                default: ;
            endcase
        end
    end

    xcvr_delay_timer #(
        .CNT_W(CNT_W)
    ) timer_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(t_clear),
        .run  (t_run),
        .tick (tick),
        .limit(t_limit),
        .done (t_done)
    );

    // next-state logic
    always_comb begin
        en_fall       = st_q.en_prev && !en_pin;
        st_d          = st_q;
        st_d.en_prev  = en_pin;
        if (!supply_ok) begin
            st_d.mode       = MODE_OFF;
            st_d.wake_flag  = 1'b0;
            st_d.src_local  = 1'b0;
            st_d.sleep_pend = 1'b0;
        end else begin
            case (st_q.mode)
                MODE_OFF: begin
                    st_d.mode       = MODE_PRE;
                    st_d.wake_flag  = 1'b0;
                    st_d.src_local  = 1'b0;
                    st_d.sleep_pend = 1'b0;
                end
                MODE_PRE: begin
                    if (en_pin) begin
                        st_d.wake_flag = 1'b0;
                        st_d.src_local = 1'b0;
                    end
                    if (t_done) begin
                        st_d.mode = MODE_RUN;
                    end
                end
                MODE_RUN: begin
                    if (en_fall && txd_pin) begin
                        st_d.sleep_pend = 1'b1;
                    end else if (en_pin) begin
                        st_d.sleep_pend = 1'b0;
                    end
                    if (t_done) begin
                        st_d.mode       = MODE_SLEEP;
                        st_d.sleep_pend = 1'b0;
                    end
                end
                MODE_SLEEP: begin
                    if (wake_local || wake_remote) begin
                        st_d.mode      = MODE_PRE;
                        st_d.wake_flag = 1'b1;
                        st_d.src_local = wake_local;
                    end
                end
                default: st_d.mode = MODE_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_OFF, wake_flag: 1'b0, src_local: 1'b0,
                      sleep_pend: 1'b0, en_prev: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    xcvr_mode_decode decode_i (
        .mode         (st_q.mode),
        .wake_flag    (st_q.wake_flag),
        .src_local    (st_q.src_local),
        .inh_on       (inh_on),
        .tx_path_en   (tx_path_en),
        .term_on      (term_on),
        .rxd_force_low(rxd_force_low),
        .txd_strong_pd(txd_strong_pd)
    );

    assign mode_o = st_q.mode;

endmodule

// File: rtl/xcvr_mode_ctrl_chk.sv
module xcvr_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_ok,
    input logic       en_pin,
    input logic [1:0] mode_o,
    input logic       inh_on,
    input logic       tx_path_en,
    input logic       term_on,
    input logic       rxd_force_low,
    input logic       txd_strong_pd
);

    // R3
    supply_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (mode_o == 2'b00) && !inh_on && !term_on && !tx_path_en);

    // R6
    sleep_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'b10) && (mode_o != 2'b11) |=> (mode_o != 2'b11));

    // R6
    no_sleep_while_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10) && en_pin |=> (mode_o != 2'b11));

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01) && en_pin && supply_ok |=> !rxd_force_low && !txd_strong_pd);

    // R9
    source_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txd_strong_pd |-> rxd_force_low && (mode_o == 2'b01));

    // R8
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b11) |-> !inh_on && !term_on && !tx_path_en && !rxd_force_low);

    // R5
    tx_needs_inh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_path_en |-> inh_on && term_on && !rxd_force_low && (mode_o == 2'b10));

endmodule

bind xcvr_mode_ctrl xcvr_mode_ctrl_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .en_pin       (en_pin),
    .mode_o       (mode_o),
    .inh_on       (inh_on),
    .tx_path_en   (tx_path_en),
    .term_on      (term_on),
    .rxd_force_low(rxd_force_low),
    .txd_strong_pd(txd_strong_pd)
);

// File: tb/xcvr_mode_ctrl_tb_top.sv
module xcvr_mode_ctrl_tb_top;

    localparam int NT = 4;
    localparam int ST = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       supply_ok = 1'b0;
    logic       en_pin = 1'b0;
    logic       txd_pin = 1'b1;
    logic       wake_remote = 1'b0;
    logic       wake_local = 1'b0;
    logic [1:0] mode_o;
    logic       inh_on, tx_path_en, term_on, rxd_force_low, txd_strong_pd;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    xcvr_mode_ctrl #(.NORM_TICKS(NT), .SLEEP_TICKS(ST)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
        .en_pin(en_pin), .txd_pin(txd_pin), .wake_remote(wake_remote),
        .wake_local(wake_local), .mode_o(mode_o), .inh_on(inh_on),
        .tx_path_en(tx_path_en), .term_on(term_on),
        .rxd_force_low(rxd_force_low), .txd_strong_pd(txd_strong_pd)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // packs {mode, inh, tx, term, rxd_low, strong}
    function automatic logic [7:0] outs();
        return {1'b0, mode_o, inh_on, tx_path_en, term_on, rxd_force_low, txd_strong_pd};
    endfunction

    function automatic logic [7:0] exp_o(input logic [1:0] m, input logic i, input logic t,
                                         input logic r, input logic w, input logic s);
        return {1'b0, m, i, t, r, w, s};
    endfunction

    task automatic t_reset();
        step(2);
        chk("R1 in reset", outs(), exp_o(2'b00, 0, 0, 0, 0, 0));
        rst_n = 1'b1;
        step(2);
        chk("R1 no supply", outs(), exp_o(2'b00, 0, 0, 0, 0, 0));
    endtask

    task automatic t_powerup();
        supply_ok = 1'b1;
        step(1);
        chk("R2 power-up", outs(), exp_o(2'b01, 1, 0, 1, 0, 0));
    endtask

    task automatic t_to_normal();
        tick = 1'b0;
        en_pin = 1'b1;
        step(10);
        chk("R4 no tick no progress", {6'd0, mode_o}, 8'h01);
        en_pin = 1'b0;
        step(1);
        tick = 1'b1;
        en_pin = 1'b1;
        step(NT - 1);
        chk("R4 before delay", {6'd0, mode_o}, 8'h01);
        en_pin = 1'b0;
        step(1);
        en_pin = 1'b1;
        step(NT - 1);
        chk("R4 restart after low", {6'd0, mode_o}, 8'h01);
        step(1);
        chk("R4 normal reached", {6'd0, mode_o}, 8'h02);
        chk("R5 normal outputs", outs(), exp_o(2'b10, 1, 1, 1, 0, 0));
    endtask

    task automatic t_fall_txd_low();
        txd_pin = 1'b0;
        en_pin = 1'b0;
        step(1);
        txd_pin = 1'b1;
        step(12);
        chk("R7 stays normal", {6'd0, mode_o}, 8'h02);
        en_pin = 1'b1;
        step(1);
    endtask

    task automatic t_sleep_cancel();
        en_pin = 1'b0;
        step(2);
        en_pin = 1'b1;
        step(6);
        chk("R6 cancel", {6'd0, mode_o}, 8'h02);
    endtask

    task automatic go_sleep(input string tag);
        en_pin = 1'b0;
        txd_pin = 1'b1;
        step(ST);
        chk({tag, " before delay"}, {6'd0, mode_o}, 8'h02);
        step(1);
        chk({tag, " sleep"}, outs(), exp_o(2'b11, 0, 0, 0, 0, 0));
    endtask

    task automatic t_sleep_hold();
        en_pin = 1'b1;
        step(3);
        en_pin = 1'b0;
        txd_pin = 1'b0;
        step(5);
        txd_pin = 1'b1;
        step(20);
        chk("R12 sleep held", outs(), exp_o(2'b11, 0, 0, 0, 0, 0));
    endtask

    task automatic wake_and_run(input logic loc, input logic rem, input logic exp_s, input string tag);
        wake_local = loc;
        wake_remote = rem;
        step(1);
        wake_local = 1'b0;
        wake_remote = 1'b0;
        chk({tag, " wake"}, outs(), exp_o(2'b01, 1, 0, 1, 1, exp_s));
        wake_remote = 1'b1;
        wake_local = 1'b1;
        step(1);
        wake_remote = 1'b0;
        wake_local = 1'b0;
        chk("R11 pulse in pre-normal", outs(), exp_o(2'b01, 1, 0, 1, 1, exp_s));
        en_pin = 1'b1;
        step(1);
        chk("R10 flags cleared", outs(), exp_o(2'b01, 1, 0, 1, 0, 0));
        step(NT - 1);
        chk({tag, " normal"}, {6'd0, mode_o}, 8'h02);
    endtask

    task automatic t_wake_in_normal();
        wake_local = 1'b1;
        step(1);
        wake_local = 1'b0;
        chk("R11 pulse in normal", outs(), exp_o(2'b10, 1, 1, 1, 0, 0));
    endtask

    task automatic t_supply_drop();
        supply_ok = 1'b0;
        step(1);
        chk("R3 drop from normal", outs(), exp_o(2'b00, 0, 0, 0, 0, 0));
        supply_ok = 1'b1;
        step(1);
        chk("R2 re-power", outs(), exp_o(2'b01, 1, 0, 1, 0, 0));
        step(NT);
        go_sleep("R6 again");
        supply_ok = 1'b0;
        step(1);
        chk("R3 drop from sleep", outs(), exp_o(2'b00, 0, 0, 0, 0, 0));
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_to_normal();
        t_fall_txd_low();
        t_sleep_cancel();
        go_sleep("R6");
        chk("R8 sleep outputs", outs(), exp_o(2'b11, 0, 0, 0, 0, 0));
        t_sleep_hold();
        wake_and_run(1'b1, 1'b0, 1'b1, "R9 local");
        go_sleep("R6 after local");
        wake_and_run(1'b0, 1'b1, 1'b0, "R9 remote");
        go_sleep("R6 after remote");
        wake_and_run(1'b1, 1'b1, 1'b1, "R9 both");
        t_wake_in_normal();
        t_supply_drop();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule